// File: doc/BRIEF.md
# Direct-Page Two-Operand Memory Operation Sequencer

This block is the bus-cycle engine for one family of instructions of an 8-bit processor: the two-operand operations whose destination lives in the direct page. When the opcode has been fetched elsewhere, the core presents it with a one-cycle `start` strobe. The sequencer then fetches the operand bytes through the program counter, reads and writes memory one access per cycle, and updates the N, V, H, Z and C flags. At the end it raises `done` for one cycle.

Six kinds of instruction are covered. Memory-to-memory ALU operations combine a source byte into a destination byte. Immediate-to-memory ALU operations combine an immediate byte into a destination byte. Compares in both forms touch only the flags, and their last cycle is a second read of the destination. Two moves complete the set. The memory-to-memory move never reads its destination. The immediate move does a throw-away read of its destination before the store. Every direct-page address takes its high byte from `dp_sel`, so the page is either 0x00 or 0x01.

The controller has six states: IDLE, FETCH_A, READ_SRC, FETCH_B, READ_DST and FINAL. Its transitions are:
- IDLE to FETCH_A when `start` arrives with a valid opcode.
- FETCH_A to READ_SRC for memory-to-memory forms, or to FETCH_B for immediate forms.
- READ_SRC to FETCH_B.
- FETCH_B to FINAL for the memory-to-memory move, otherwise to READ_DST.
- READ_DST to FINAL.
- FINAL to IDLE, which also raises `done`.

Top module: `dp_memop_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `pc` equals RESET_PC (default 0x0200), `bus_rd`, `bus_wr`, `done` and `busy` are low, and all five flags are 0.
- R2: Every direct-page access (source read, destination read, destination write) drives the address {7'b0, dp_sel, offset}, so it falls in page 0x00 or page 0x01.
- R3: A memory-to-memory ALU opcode (0x09, 0x29, 0x49, 0x89, 0xA9) makes exactly five bus cycles in this order:
  - read pc (source offset);
  - read the source;
  - read pc+1 (destination offset);
  - read the destination;
  - write the result to the destination.
- R4: An immediate ALU opcode (0x18, 0x38, 0x58, 0x98, 0xB8) makes exactly four bus cycles: read pc (immediate), read pc+1 (offset), read the destination, write the result.
- R5: The compares 0x69 (memory form, cycles as in R3) and 0x78 (immediate form, cycles as in R4) replace the final write with a second read of the destination. Memory is left unchanged. N and Z come from destination minus source, and C=1 when destination >= source (unsigned). V and H are kept.
- R6: Opcode 0xFA makes four cycles: read pc, read the source, read pc+1, write the source value to the destination. It never reads the destination and leaves all flags unchanged.
- R7: Opcode 0x8F makes four cycles: read pc, read pc+1, a dummy read of the destination, then a write of the immediate. Flags are unchanged.
- R8: Opcode bits [7:5] select the function: 0 OR, 1 AND, 2 EOR, 3 compare, 4 add, 5 subtract. N is result bit 7 and Z flags a zero result. OR, AND and EOR leave V, H and C unchanged.
- R9: Add computes destination + source + C. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. Subtract is the same as add with the source bitwise inverted.
- R10: Each operand fetch reads address `pc` and advances `pc` by one. No other cycle changes `pc`, so every instruction advances it by exactly two.
- R11: Exactly one of `bus_rd` and `bus_wr` is high in each cycle of an instruction, and both are low while idle.
- R12: `done` is a one-cycle pulse in the cycle after the last bus cycle. Any opcode outside R3 to R7 is ignored: no bus cycle, no change to `pc`, no `done`.
- R13: A `start` strobe that arrives while an instruction is running is ignored and does not change the running bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opcode-valid strobe, taken only while idle |
| opcode | input | 8 | Opcode presented with `start` |
| dp_sel | input | 1 | Direct-page select, high byte of direct-page addresses |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe for this cycle |
| bus_wr | output | 1 | Write strobe for this cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid within the read cycle |
| pc | output | 16 | Program counter |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction-complete pulse |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_h | output | 1 | Half-carry flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest cases to provoke from the ports are the carry-dependent add and subtract results. The carry they consume is left behind by whichever instruction ran before, so the stimulus table is ordered on purpose. A compare with equal operands sets C just before an add, and the add then clears C just before a subtract that overflows. A busy-time `start` is injected mid-instruction, and its effect can only be seen as a change in the bus trace. For that reason every instruction's read/write/address/data sequence is recorded per cycle and compared in full.

// File: rtl/dp_memop_pkg.sv
package dp_memop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_READ_SRC,
        ST_FETCH_B,
        ST_READ_DST,
        ST_FINAL
    } seq_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_MM_ALU,
        K_MM_CMP,
        K_MM_MOV,
        K_IM_ALU,
        K_IM_CMP,
        K_IM_MOV
    } op_kind_t;

    // values follow opcode bits [7:5]; the decoder relies on this order
    typedef enum logic [2:0] {
        F_OR   = 3'd0,
        F_AND  = 3'd1,
        F_EOR  = 3'd2,
        F_CMP  = 3'd3,
        F_ADC  = 3'd4,
        F_SBC  = 3'd5,
        F_PASS = 3'd6
    } alu_fn_t;

endpackage

// File: rtl/dp_memop_decode.sv
module dp_memop_decode
    import dp_memop_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0] opcode,
    output op_kind_t         kind,
    output alu_fn_t          fn
);

    localparam logic [3:0] LOW_MEM = 4'h9;
    localparam logic [3:0] LOW_IMM = 4'h8;
    localparam logic [OPC_W-1:0] OPC_MOV_IMM = OPC_W'(8'h8F);
    localparam logic [OPC_W-1:0] OPC_MOV_MEM = OPC_W'(8'hFA);

    logic [2:0] grp;
    logic       grp_ok;

    always_comb begin
        grp    = opcode[OPC_W-1 -: 3];
        grp_ok = (grp <= 3'd5);
        kind   = K_NONE;
        fn     = F_PASS;
        if (opcode == OPC_MOV_IMM) begin
            kind = K_IM_MOV;
        end else if (opcode == OPC_MOV_MEM) begin
            kind = K_MM_MOV;
        end else if (grp_ok && opcode[3:0] == LOW_MEM && !opcode[4]) begin
            fn   = alu_fn_t'(grp);
            kind = (grp == 3'd3) ? K_MM_CMP : K_MM_ALU;
        end else if (grp_ok && opcode[3:0] == LOW_IMM && opcode[4]) begin
            fn   = alu_fn_t'(grp);
            kind = (grp == 3'd3) ? K_IM_CMP : K_IM_ALU;
        end
    end

endmodule

// File: rtl/dp_memop_alu.sv
module dp_memop_alu
    import dp_memop_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_fn_t       fn,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          n,
    output logic          v,
    output logic          h,
    output logic          z,
    output logic          c,
    output logic          upd_c,
    output logic          upd_vh
);

    localparam int HW = DW / 2;

    logic [DW-1:0] addend;
    logic [DW:0]   sum;
    logic [DW:0]   diff;
    logic [HW:0]   half;

    always_comb begin
        addend = (fn == F_SBC) ? ~rhs : rhs;
        sum    = {1'b0, lhs} + {1'b0, addend} + {{DW{1'b0}}, cin};
        half   = {1'b0, lhs[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, cin};
        diff   = {1'b0, lhs} - {1'b0, rhs};
        res    = rhs;
        c      = 1'b0;
        v      = 1'b0;
        h      = 1'b0;
        upd_c  = 1'b0;
        upd_vh = 1'b0;
        unique case (fn)
            F_OR:  res = lhs | rhs;
            F_AND: res = lhs & rhs;
            F_EOR: res = lhs ^ rhs;
            F_CMP: begin
                res   = diff[DW-1:0];
                c     = ~diff[DW];
                upd_c = 1'b1;
            end
            F_ADC, F_SBC: begin
                res    = sum[DW-1:0];
                c      = sum[DW];
                h      = half[HW];
                v      = ~(lhs[DW-1] ^ addend[DW-1]) & (lhs[DW-1] ^ sum[DW-1]);
                upd_c  = 1'b1;
                upd_vh = 1'b1;
            end
            default: res = rhs;
        endcase
        n = res[DW-1];
        z = (res == '0);
    end

endmodule

// File: rtl/dp_memop_seq.sv
module dp_memop_seq
    import dp_memop_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] RESET_PC = 'h0200,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic          dp_sel,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] pc,
    output logic          busy,
    output logic          done,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_h,
    output logic          flag_z,
    output logic          flag_c
);

    localparam int PAD_W = AW - DW - 1;

    seq_state_t state_q, state_d;
    op_kind_t   kind_q, dec_kind;
    alu_fn_t    fn_q, dec_fn;
    logic       dec_valid;

    logic [DW-1:0] opnd_q;
    logic [DW-1:0] dst_off_q;
    logic [DW-1:0] res_q;
    logic [AW-1:0] pc_q;
    logic          done_q;
    logic          n_q, v_q, h_q, z_q, c_q;

    logic          is_mem_form, is_cmp, is_mov;
    logic [DW-1:0] alu_res;
    logic          alu_n, alu_v, alu_h, alu_z, alu_c, alu_upd_c, alu_upd_vh;

    dp_memop_decode #(.OPC_W(8)) u_dec (
        .opcode (opcode),
        .kind   (dec_kind),
        .fn     (dec_fn)
    );

    assign dec_valid = (dec_kind != K_NONE);

    dp_memop_alu #(.DW(DW)) u_alu (
        .fn     (fn_q),
        .lhs    (bus_rdata),
        .rhs    (opnd_q),
        .cin    (c_q),
        .res    (alu_res),
        .n      (alu_n),
        .v      (alu_v),
        .h      (alu_h),
        .z      (alu_z),
        .c      (alu_c),
        .upd_c  (alu_upd_c),
        .upd_vh (alu_upd_vh)
    );

    always_comb begin
        is_mem_form = (kind_q == K_MM_ALU) || (kind_q == K_MM_CMP) || (kind_q == K_MM_MOV);
        is_cmp      = (kind_q == K_MM_CMP) || (kind_q == K_IM_CMP);
        is_mov      = (kind_q == K_MM_MOV) || (kind_q == K_IM_MOV);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start && dec_valid) state_d = ST_FETCH_A;
            ST_FETCH_A:  state_d = is_mem_form ? ST_READ_SRC : ST_FETCH_B;
            ST_READ_SRC: state_d = ST_FETCH_B;
            ST_FETCH_B:  state_d = (kind_q == K_MM_MOV) ? ST_FINAL : ST_READ_DST;
            ST_READ_DST: state_d = ST_FINAL;
            ST_FINAL:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        bus_addr  = pc_q;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = res_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH_A, ST_FETCH_B: begin
                bus_addr = pc_q;
                bus_rd   = 1'b1;
            end
            ST_READ_SRC: begin
                bus_addr = {{PAD_W{1'b0}}, dp_sel, opnd_q};
                bus_rd   = 1'b1;
            end
            ST_READ_DST: begin
                bus_addr = {{PAD_W{1'b0}}, dp_sel, dst_off_q};
                bus_rd   = 1'b1;
            end
            ST_FINAL: begin
                bus_addr = {{PAD_W{1'b0}}, dp_sel, dst_off_q};
                bus_rd   = is_cmp;
                bus_wr   = !is_cmp;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_NONE;
            fn_q      <= F_PASS;
            opnd_q    <= '0;
            dst_off_q <= '0;
            res_q     <= '0;
            pc_q      <= RESET_PC;
            done_q    <= 1'b0;
            n_q       <= 1'b0;
            v_q       <= 1'b0;
            h_q       <= 1'b0;
            z_q       <= 1'b0;
            c_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && dec_valid) begin
                        kind_q <= dec_kind;
                        fn_q   <= dec_fn;
                    end
                end
                ST_FETCH_A: begin
                    opnd_q <= bus_rdata;
                    pc_q   <= pc_q + 1'b1;
                end
                ST_READ_SRC: opnd_q <= bus_rdata;
                ST_FETCH_B: begin
                    dst_off_q <= bus_rdata;
                    pc_q      <= pc_q + 1'b1;
                    if (kind_q == K_MM_MOV) res_q <= opnd_q;
                end
                ST_READ_DST: begin
                    if (is_mov) begin
                        res_q <= opnd_q;
                    end else begin
                        res_q <= alu_res;
                        n_q   <= alu_n;
                        z_q   <= alu_z;
                        if (alu_upd_c) c_q <= alu_c;
                        if (alu_upd_vh) begin
                            v_q <= alu_v;
                            h_q <= alu_h;
                        end
                    end
                end
                ST_FINAL: done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign pc     = pc_q;
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign flag_n = n_q;
    assign flag_v = v_q;
    assign flag_h = h_q;
    assign flag_z = z_q;
    assign flag_c = c_q;

endmodule

// File: rtl/dp_memop_seq_chk.sv
module dp_memop_seq_chk
    import dp_memop_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_valid,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [AW-1:0] pc,
    input logic          done,
    input seq_state_t    st,
    input op_kind_t      kind,
    input logic [4:0]    flags
);

    logic fetch_st, dp_st, mov_k, cmp_k;
    assign fetch_st = (st == ST_FETCH_A) || (st == ST_FETCH_B);
    assign dp_st    = (st == ST_READ_SRC) || (st == ST_READ_DST) || (st == ST_FINAL);
    assign mov_k    = (kind == K_MM_MOV) || (kind == K_IM_MOV);
    assign cmp_k    = (kind == K_MM_CMP) || (kind == K_IM_CMP);

    p_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dp_st |-> bus_addr[AW-1:DW+1] == '0);

    p_cmp_reread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FINAL && cmp_k) |-> (bus_rd && !bus_wr));

    p_mov_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mov_k && st != ST_IDLE) |=> $stable(flags));

    p_fetch_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_st |-> (bus_rd && bus_addr == pc));

    p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_st |=> pc == $past(pc) + {{(AW-1){1'b0}}, 1'b1});

    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_st |=> $stable(pc));

    p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> $countones({bus_rd, bus_wr}) == 1);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!bus_rd && !bus_wr));

    p_done_after_final_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FINAL) |=> done);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ignore_bad_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(start && op_valid)) |=> st == ST_IDLE);

    p_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && start) |=> st != ST_FETCH_A);

endmodule

bind dp_memop_seq dp_memop_seq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (dec_valid),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pc       (pc),
    .done     (done),
    .st       (state_q),
    .kind     (kind_q),
    .flags    ({flag_n, flag_v, flag_h, flag_z, flag_c})
);

// File: tb/sim_dp_memop_seq.sv
module sim_dp_memop_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        dp_sel = 1'b0;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [15:0] pc;
    logic        busy, done;
    logic        flag_n, flag_v, flag_h, flag_z, flag_c;

    logic [7:0] mem [0:1023];
    int errors = 0;
    int checks = 0;
    logic [15:0] pc_model = 16'h0200;
    logic [4:0]  fl_model = 5'b0;   // {n,v,h,z,c}

    always #5 clk = ~clk;

    assign bus_rdata = mem[bus_addr[9:0]];

    dp_memop_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .dp_sel(dp_sel),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pc(pc), .busy(busy), .done(done),
        .flag_n(flag_n), .flag_v(flag_v), .flag_h(flag_h), .flag_z(flag_z), .flag_c(flag_c)
    );

    // {opcode, page, src_off, dst_off, src_or_imm, dst_value}
    localparam int NV = 14;
    localparam logic [47:0] VEC [NV] = '{
        {8'h09, 8'h00, 8'h10, 8'h20, 8'h0F, 8'hF0},  // R3 R8 OR
        {8'h29, 8'h01, 8'h11, 8'h21, 8'h0F, 8'hF0},  // R3 R2 AND -> zero
        {8'h49, 8'h00, 8'h12, 8'h22, 8'hAA, 8'hFF},  // R3 EOR, busy start injected (R13)
        {8'h69, 8'h00, 8'h13, 8'h23, 8'h40, 8'h40},  // R5 equal compare sets C
        {8'h89, 8'h00, 8'h14, 8'h24, 8'h01, 8'h0F},  // R9 add with carry in, half carry
        {8'hA9, 8'h01, 8'h15, 8'h25, 8'h01, 8'h80},  // R9 subtract, overflow
        {8'h18, 8'h00, 8'h00, 8'h26, 8'h01, 8'h80},  // R4 OR immediate
        {8'h38, 8'h01, 8'h00, 8'h27, 8'h7F, 8'hFF},  // R4 AND immediate
        {8'h58, 8'h00, 8'h00, 8'h28, 8'hFF, 8'hFF},  // R4 EOR immediate -> zero
        {8'h78, 8'h00, 8'h00, 8'h29, 8'h50, 8'h30},  // R5 compare immediate, borrow
        {8'h98, 8'h00, 8'h00, 8'h2A, 8'h7F, 8'h01},  // R9 add overflow
        {8'hB8, 8'h01, 8'h00, 8'h2B, 8'h01, 8'h00},  // R9 subtract immediate
        {8'h8F, 8'h01, 8'h00, 8'h30, 8'h5A, 8'h11},  // R7 immediate move
        {8'hFA, 8'h00, 8'h31, 8'h32, 8'hC3, 8'h77}   // R6 memory move
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference: returns {result, n, v, h, z, c}
    function automatic logic [12:0] ref_alu(input logic [2:0] f, input logic [7:0] a,
                                            input logic [7:0] b, input logic [4:0] fl);
        logic [7:0] r, bb;
        logic [8:0] s, d;
        logic [4:0] hs;
        logic n, v, h, z, c;
        {n, v, h, z, c} = fl;
        r = 8'h00;
        case (f)
            3'd0: r = a | b;
            3'd1: r = a & b;
            3'd2: r = a ^ b;
            3'd3: begin
                d = {1'b0, a} - {1'b0, b};
                r = d[7:0];
                c = (a >= b);
            end
            default: begin
                bb = (f == 3'd5) ? ~b : b;
                s  = {1'b0, a} + {1'b0, bb} + {8'h00, c};
                hs = {1'b0, a[3:0]} + {1'b0, bb[3:0]} + {4'h0, c};
                r  = s[7:0];
                c  = s[8];
                h  = hs[4];
                v  = (a[7] == bb[7]) && (s[7] != a[7]);
            end
        endcase
        n = r[7];
        z = (r == 8'h00);
        return {r, n, v, h, z, c};
    endfunction

    task automatic run_vec(input logic [47:0] vv, input bit poke);
        logic [7:0] op, so, dso, sv, dv, wexp;
        logic       pg;
        logic [15:0] sa, da;
        logic [1:0]  ek [6];
        logic [15:0] ea [6];
        logic [1:0]  ak [6];
        logic [15:0] aa [6];
        logic [7:0]  ad [6];
        int en, an, cyc;
        bit mm, cmp, mov, seq_ok, saw_done;
        logic [12:0] rr;
        op = vv[47:40]; pg = vv[32]; so = vv[31:24]; dso = vv[23:16];
        sv = vv[15:8];  dv = vv[7:0];
        sa = {7'b0, pg, so};
        da = {7'b0, pg, dso};
        mm  = (op[3:0] == 4'h9) || (op == 8'hFA);
        cmp = (op == 8'h69) || (op == 8'h78);
        mov = (op == 8'h8F) || (op == 8'hFA);
        mem[pc_model[9:0]]        = mm ? so : sv;
        mem[pc_model[9:0] + 10'd1] = dso;
        if (mm) mem[sa[9:0]] = sv;
        mem[da[9:0]] = dv;
        // expected sequence (1 = read, 2 = write)
        en = 0;
        ek[en] = 2'd1; ea[en] = pc_model; en++;
        if (mm) begin ek[en] = 2'd1; ea[en] = sa; en++; end
        ek[en] = 2'd1; ea[en] = pc_model + 16'd1; en++;
        if (op != 8'hFA) begin ek[en] = 2'd1; ea[en] = da; en++; end
        ek[en] = cmp ? 2'd1 : 2'd2; ea[en] = da; en++;
        rr = ref_alu(op[7:5], dv, sv, fl_model);
        wexp = mov ? sv : rr[12:5];
        if (!mov) fl_model = rr[4:0];
        // launch
        @(negedge clk);
        opcode = op; dp_sel = pg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        an = 0; cyc = 0; saw_done = 1'b0;
        while (cyc < 12) begin
            if (done) begin saw_done = 1'b1; break; end
            if ((bus_rd || bus_wr) && an < 6) begin
                ak[an] = bus_wr ? 2'd2 : 2'd1;
                aa[an] = bus_addr;
                ad[an] = bus_wdata;
                if (bus_wr) mem[bus_addr[9:0]] = bus_wdata;
                an++;
            end
            cyc++;
            if (poke && cyc == 2) begin start = 1'b1; opcode = 8'h8F; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check(saw_done, "R12", $sformatf("done seen op %0h", op), {31'b0, saw_done}, 32'd1);
        seq_ok = (an == en);
        for (int i = 0; i < 6; i++) begin
            if (seq_ok && i < en) begin
                if (ak[i] != ek[i] || aa[i] != ea[i]) seq_ok = 1'b0;
                if (ek[i] == 2'd2 && ad[i] != wexp) seq_ok = 1'b0;
            end
        end
        // R3 R4 R5 R6 R7 R13: bus trace per opcode
        check(seq_ok, poke ? "R13" : (mm ? "R3/R5/R6" : "R4/R5/R7"),
              $sformatf("bus trace op %0h cycles", op), an, en);
        check(mem[da[9:0]] == (cmp ? dv : wexp), cmp ? "R5" : "R8",
              $sformatf("dest value op %0h", op), mem[da[9:0]], cmp ? dv : wexp);
        check({flag_n, flag_v, flag_h, flag_z, flag_c} == fl_model, mov ? "R6" : "R9",
              $sformatf("flags nvhzc op %0h", op),
              {flag_n, flag_v, flag_h, flag_z, flag_c}, fl_model);
        pc_model = pc_model + 16'd2;
        check(pc == pc_model, "R10", $sformatf("pc after op %0h", op), pc, pc_model);
        @(negedge clk);
        check(!done, "R12", "done is one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic try_ignored(input logic [7:0] op);
        bit quiet;
        logic [15:0] pc0;
        pc0 = pc;
        @(negedge clk);
        opcode = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 5; i++) begin
            if (bus_rd || bus_wr || done || busy) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R12", $sformatf("opcode %0h ignored", op), {31'b0, quiet}, 32'd1);
        check(pc == pc0, "R12", $sformatf("pc kept for %0h", op), pc, pc0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pc == 16'h0200, "R1", "pc in reset", pc, 32'h0200);
        check(!bus_rd && !bus_wr && !done && !busy, "R1", "strobes in reset",
              {bus_rd, bus_wr, done, busy}, 0);
        check({flag_n, flag_v, flag_h, flag_z, flag_c} == 5'b0, "R1", "flags in reset",
              {flag_n, flag_v, flag_h, flag_z, flag_c}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc == 16'h0200 && !bus_rd && !bus_wr, "R1", "after release",
              pc, 32'h0200);
        for (int k = 0; k < NV; k++) run_vec(VEC[k], k == 2);
        // R12 unknown opcodes
        try_ignored(8'h00);
        try_ignored(8'h19);
        try_ignored(8'hC9);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule